// File: doc/BRIEF.md
# Flash Access Mode Arbiter

This block decides which of three requesters may drive a serial flash controller next. A word-aligned fetch path has the highest priority. An indirect read/write engine can be cut off by a fetch. A status-polling engine cannot be cut off. The arbiter watches the busy levels of the two lower-priority engines. When a fetch arrives, it either aborts the indirect transfer, waits out the poll, or waits out a programmed settle period after a flash write. It then hands the controller to the fetch with a one-cycle grant.

The fetch side is a valid/ready handshake. The requester raises `fetch_valid` with `fetch_addr` and holds both steady until it sees `fetch_ready`. `fetch_ready` is a registered one-cycle pulse, and the transfer takes place in that cycle. The requester may drop `fetch_valid` after the pulse or keep it raised for a new fetch. While the arbiter is pre-empting, waiting for a settle period or waiting for a poll, it applies back-pressure by holding `fetch_ready` low.

All other pins are plain levels or pulses. On an abort, the arbiter latches the number of bytes still outstanding. It also flushes the data buffer unless the keep control is set, in which case the buffered data stays where it is for software to drain. A poll that times out while a fetch is waiting raises a fault and stops the poll.

Top module: `flash_mode_arbiter`

## Requirements
- R1: After reset, `fetch_ready`, `fetch_err`, `ind_abort`, `fifo_flush` and `poll_stop` are 0, and `abort_bytes` and `grant_addr` are 0.
- R2: `fetch_ready` is never high in two consecutive cycles. If `fetch_valid` is held high while no engine is busy and no settle period is running, a grant pulse follows every second cycle.
- R3: In the grant cycle, `grant_addr` equals the requested address with bits [1:0] forced to 00.
- R4: If a fetch is requested while an indirect read is busy (`ind_busy`=1, `ind_write`=0), `ind_abort` and `fetch_ready` both pulse in the next cycle. From that cycle on, `abort_bytes` equals the `ind_left` value of the request cycle.
- R5: If a fetch is requested while an indirect write is busy, `ind_abort` pulses in the next cycle. `fetch_ready` follows exactly `wait_cnt`+1 cycles after the `ind_abort` pulse.
- R6: If an indirect write ends by itself in cycle c (the first cycle with `ind_busy` low) and a fetch is requested in cycle c, `fetch_ready` pulses in cycle c+`wait_cnt`+2 and `ind_abort` stays low.
- R7: A fetch requested while `poll_busy` is high never causes `ind_abort`. If `poll_match` is seen in cycle c+m (request in cycle c, m ≥ 1, m ≤ `poll_limit`+1), `fetch_ready` pulses in cycle c+m+1 with `fetch_err` low.
- R8: If no match comes, `fetch_ready`, `fetch_err` and `poll_stop` all pulse in cycle c+`poll_limit`+2.
- R9: When a match and the poll timeout fall in the same cycle, the match wins and `fetch_err` stays low.
- R10: `fifo_flush` pulses together with `ind_abort` when `keep_fifo` is 0, and never pulses when `keep_fifo` is 1.
- R11: `abort_bytes` changes only in a cycle where `ind_abort` is high. Grants without an abort leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | One-cycle grant pulse to the fetch path |
| fetch_err | output | 1 | Fetch granted with fault (poll timeout) |
| grant_addr | output | ADDR_W | Word-aligned address of the granted fetch |
| ind_busy | input | 1 | Indirect engine transfer in progress |
| ind_write | input | 1 | Indirect transfer is a write |
| ind_left | input | CNT_W | Bytes still to move in the indirect transfer |
| ind_abort | output | 1 | Abort pulse to the indirect engine |
| abort_bytes | output | CNT_W | Bytes cut off by the last abort |
| keep_fifo | input | 1 | Keep buffered data on abort |
| fifo_flush | output | 1 | Flush pulse to the data buffer |
| poll_busy | input | 1 | Status polling in progress |
| poll_match | input | 1 | Polled status matched this cycle |
| poll_stop | output | 1 | Stop pulse to the polling engine on timeout |
| poll_limit | input | TMO_W | Poll timeout in cycles, counted from the start of the wait |
| wait_cnt | input | WAIT_W | Settle period after a flash write |

## Verification
The poll match and the poll timeout can land in the same cycle. One stimulus vector drives `poll_match` in exactly the cycle where the wait counter reaches `poll_limit`. The bench then expects a clean grant one cycle later with no fault and no stop pulse. A second collision occurs when an indirect write ends in the very cycle a fetch arrives. The bench raises both together and requires the full settle delay before the grant, with no abort.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_SETTLE = 2'd1,
    ARB_POLL   = 2'd2
  } arb_state_t;
endpackage

// File: rtl/fa_settle_timer.sv
module fa_settle_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              idle
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R5
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !idle);
endmodule

// File: rtl/fa_poll_guard.sv
module fa_poll_guard #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R8
  guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/fa_abort_capture.sv
module fa_abort_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] left,
  input  logic             keep,
  output logic             abort_pulse,
  output logic             flush_pulse,
  output logic [CNT_W-1:0] bytes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      flush_pulse <= 1'b0;
      bytes       <= '0;
    end else begin
      abort_pulse <= fire;
      flush_pulse <= fire && !keep;
      if (fire) bytes <= left;
    end
  end

  // R10
  flush_only_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> abort_pulse);

  // R11
  bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> $stable(bytes));
endmodule

// File: rtl/flash_mode_arbiter.sv
module flash_mode_arbiter
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              fetch_err,
  output logic [ADDR_W-1:0] grant_addr,
  input  logic              ind_busy,
  input  logic              ind_write,
  input  logic [CNT_W-1:0]  ind_left,
  output logic              ind_abort,
  output logic [CNT_W-1:0]  abort_bytes,
  input  logic              keep_fifo,
  output logic              fifo_flush,
  input  logic              poll_busy,
  input  logic              poll_match,
  output logic              poll_stop,
  input  logic [TMO_W-1:0]  poll_limit,
  input  logic [WAIT_W-1:0] wait_cnt
);
  localparam int ALIGN_B = 2;

  arb_state_t state, state_nxt;
  logic busy_q, write_q, killed;
  logic write_end, fire_abort, settle_load, settle_idle, poll_exp;
  logic grant_d, err_d;

  assign write_end   = busy_q && write_q && !ind_busy && !killed;
  assign settle_load = write_end || (fire_abort && ind_write);

  fa_settle_timer #(.WAIT_W(WAIT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .load_val(wait_cnt),
    .idle(settle_idle)
  );

  fa_poll_guard #(.TMO_W(TMO_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .run(state == ARB_POLL), .limit(poll_limit),
    .expired(poll_exp)
  );

  fa_abort_capture #(.CNT_W(CNT_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .fire(fire_abort), .left(ind_left),
    .keep(keep_fifo), .abort_pulse(ind_abort), .flush_pulse(fifo_flush),
    .bytes(abort_bytes)
  );

  always_comb begin
    state_nxt  = state;
    grant_d    = 1'b0;
    err_d      = 1'b0;
    fire_abort = 1'b0;
    unique case (state)
      ARB_IDLE: begin
        if (fetch_valid && !fetch_ready) begin
          if (poll_busy) begin
            state_nxt = ARB_POLL;
          end else if (ind_busy) begin
            fire_abort = 1'b1;
            if (ind_write) state_nxt = ARB_SETTLE;
            else           grant_d   = 1'b1;
          end else if (!settle_idle || write_end) begin
            state_nxt = ARB_SETTLE;
          end else begin
            grant_d = 1'b1;
          end
        end
      end
      ARB_SETTLE: begin
        if (settle_idle && !write_end) begin
          grant_d   = 1'b1;
          state_nxt = ARB_IDLE;
        end
      end
      ARB_POLL: begin
        if (poll_match || !poll_busy) begin
          grant_d   = 1'b1;
          state_nxt = ARB_IDLE;
        end else if (poll_exp) begin
          grant_d   = 1'b1;
          err_d     = 1'b1;
          state_nxt = ARB_IDLE;
        end
      end
      default: state_nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ARB_IDLE;
      busy_q      <= 1'b0;
      write_q     <= 1'b0;
      killed      <= 1'b0;
      fetch_ready <= 1'b0;
      fetch_err   <= 1'b0;
      poll_stop   <= 1'b0;
      grant_addr  <= '0;
    end else begin
      state       <= state_nxt;
      busy_q      <= ind_busy;
      write_q     <= ind_write;
      fetch_ready <= grant_d;
      fetch_err   <= err_d;
      poll_stop   <= err_d;
      if (fire_abort)     killed <= 1'b1;
      else if (!ind_busy) killed <= 1'b0;
      if (grant_d)
        grant_addr <= {fetch_addr[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
    end
  end

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> !fetch_ready);

  // R4
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind_abort |-> ($past(ind_busy) && $past(fetch_valid)));

  // R7
  poll_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_POLL) |-> !ind_abort);

  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> ($past(state) == ARB_POLL && !$past(poll_match) && poll_stop));
endmodule

// File: tb/test_flash_mode_arbiter.sv
`timescale 1ns/1ps
module test_flash_mode_arbiter;
  typedef struct packed {
    logic [1:0]  kind;   // 0 idle, 1 indirect read, 2 indirect write, 3 poll
    logic        keep;
    logic [7:0]  left;
    logic [3:0]  wcnt;
    logic [3:0]  lim;
    logic [4:0]  mat;    // 31 = no match
    logic [15:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd0,  4'd0, 4'd0, 5'd31, 16'h1237},
    '{2'd1, 1'b0, 8'd37, 4'd0, 4'd0, 5'd31, 16'h4002},
    '{2'd1, 1'b1, 8'd5,  4'd0, 4'd0, 5'd31, 16'h00FF},
    '{2'd2, 1'b0, 8'd12, 4'd0, 4'd0, 5'd31, 16'h8001},
    '{2'd2, 1'b1, 8'd3,  4'd6, 4'd0, 5'd31, 16'hABCD},
    '{2'd3, 1'b0, 8'd0,  4'd0, 4'd9, 5'd3,  16'h0010},
    '{2'd3, 1'b0, 8'd0,  4'd0, 4'd5, 5'd31, 16'h7773},
    '{2'd3, 1'b0, 8'd0,  4'd0, 4'd4, 5'd5,  16'h2222},
    '{2'd3, 1'b0, 8'd0,  4'd0, 4'd0, 5'd31, 16'h3331},
    '{2'd0, 1'b0, 8'd0,  4'd0, 4'd0, 5'd31, 16'h5556}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, ind_busy = 0, ind_write = 0, keep_fifo = 0;
  logic poll_busy = 0, poll_match = 0;
  logic [31:0] fetch_addr = '0;
  logic [15:0] ind_left = '0, poll_limit = '0;
  logic [7:0]  wait_cnt = '0;
  logic fetch_ready, fetch_err, ind_abort, fifo_flush, poll_stop;
  logic [31:0] grant_addr;
  logic [15:0] abort_bytes;

  int errors = 0, checks = 0;
  int exp_bytes = 0;

  always #2.5 clk = ~clk;

  flash_mode_arbiter i_flash_mode_arbiter (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_err(fetch_err), .grant_addr(grant_addr),
    .ind_busy(ind_busy), .ind_write(ind_write), .ind_left(ind_left),
    .ind_abort(ind_abort), .abort_bytes(abort_bytes), .keep_fifo(keep_fifo),
    .fifo_flush(fifo_flush), .poll_busy(poll_busy), .poll_match(poll_match),
    .poll_stop(poll_stop), .poll_limit(poll_limit), .wait_cnt(wait_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    fetch_valid = 0; ind_busy = 0; ind_write = 0; poll_busy = 0; poll_match = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int rt, at, fl, er, st, er_exp, at_exp, ga;
    rt = 0; at = 0; fl = 0; er = 0; st = 0; ga = 0;
    keep_fifo = v.keep; ind_left = 16'(v.left); wait_cnt = 8'(v.wcnt);
    poll_limit = 16'(v.lim);
    fetch_addr = 32'(v.addr); fetch_valid = 1;
    ind_busy = (v.kind == 2'd1 || v.kind == 2'd2);
    ind_write = (v.kind == 2'd2);
    poll_busy = (v.kind == 2'd3);
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk);
      if (fetch_ready && rt == 0) begin rt = t; er = fetch_err; st = poll_stop; ga = grant_addr; end
      if (ind_abort) at = t;
      if (fifo_flush) fl = 1;
      if (fetch_ready) fetch_valid = 0;
      if (ind_abort) ind_busy = 0;
      poll_match = (v.kind == 2'd3) && (t == int'(v.mat));
      if (fetch_ready || poll_stop) poll_busy = 0;
    end
    er_exp = 0; at_exp = 0;
    case (v.kind)
      2'd0: rt_chk("R2", rt, 1);
      2'd1: begin rt_chk("R4", rt, 1); at_exp = 1; end
      2'd2: begin rt_chk("R5", rt, int'(v.wcnt) + 2); at_exp = 1; end
      default: begin
        if (v.mat != 5'd31 && int'(v.mat) <= int'(v.lim) + 1)
          rt_chk("R7 R9", rt, int'(v.mat) + 1);
        else begin rt_chk("R8", rt, int'(v.lim) + 2); er_exp = 1; end
      end
    endcase
    chk("R4 R5 R7 abort cycle", at, at_exp);
    chk("R8 R9 fetch_err", er, er_exp);
    chk("R8 poll_stop", st, er_exp);
    chk("R10 flush", fl, (at_exp != 0 && !v.keep) ? 1 : 0);
    chk("R3 grant_addr", ga, {16'h0, v.addr[15:2], 2'b00});
    if (at_exp != 0) exp_bytes = int'(v.left);
    chk("R4 R11 abort_bytes", abort_bytes, exp_bytes);
    quiet(20);
  endtask

  task automatic rt_chk(input string req, input int act, input int exp);
    chk(req, act, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pulses, back2back, prev, rt, at;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fetch_ready", fetch_ready, 0);
    chk("R1 fetch_err", fetch_err, 0);
    chk("R1 ind_abort", ind_abort, 0);
    chk("R1 fifo_flush", fifo_flush, 0);
    chk("R1 poll_stop", poll_stop, 0);
    chk("R1 abort_bytes", abort_bytes, 0);
    chk("R1 grant_addr", grant_addr, 0);
    rst_n = 1;
    quiet(3);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R2: held request gives isolated pulses every second cycle
    fetch_addr = 32'h0000_0104; fetch_valid = 1;
    pulses = 0; back2back = 0; prev = 0;
    for (int t = 1; t <= 6; t++) begin
      @(negedge clk);
      if (fetch_ready) pulses++;
      if (fetch_ready && prev) back2back = 1;
      prev = fetch_ready;
    end
    chk("R2 pulse count", pulses, 3);
    chk("R2 back to back", back2back, 0);
    chk("R11 bytes after plain grants", abort_bytes, exp_bytes);
    quiet(5);

    // R6: write ends in the same cycle the fetch arrives
    wait_cnt = 8'd4; keep_fifo = 0;
    ind_busy = 1; ind_write = 1;
    repeat (3) @(negedge clk);
    ind_busy = 0; fetch_valid = 1; fetch_addr = 32'h0000_0042;
    rt = 0; at = 0;
    for (int t = 1; t <= 20; t++) begin
      @(negedge clk);
      if (fetch_ready && rt == 0) rt = t;
      if (ind_abort) at = t;
      if (fetch_ready) fetch_valid = 0;
    end
    chk("R6 ready cycle", rt, 6);
    chk("R6 no abort", at, 0);
    chk("R3 grant_addr after write end", grant_addr, 32'h40);
    quiet(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule